// File: doc/BRIEF.md
# Interlocked Request/Acknowledge Bus Link

This block pairs a bus master with a register slave over a narrow shared bus. The bus has one set of lines for address and data, a direction line, an address strobe, and request and acknowledge wires. The master takes one command at a time from its local side. It puts the address and direction on the lines, with the strobe high, for a fixed number of decode cycles. It then raises request. For a write it switches the lines over to the write data at that point. For a read it releases the lines.

The slave latches the address while the strobe is high. It acknowledges only when the address falls inside its window. On a write, acknowledge means the data has been stored. On a read, acknowledge means the slave is driving register contents onto the lines. The master drops request after it sees acknowledge, and on a read it captures the data in that same cycle. The slave then drops acknowledge. That completes four edges, and only after that does the master report the result.

Each side sees the other side's handshake wire only through a two-stage synchronizer. If no slave answers within a fixed number of request cycles, the master gives up and flags an error.

Top module: `abus_link`

## Requirements
- R1: After reset, cmd_ready_o is high, bus_req_o, bus_ack_o and bus_astb_o are low, and all slave registers read back as zero.
- R2: On an accepted command, bus_lines_o carries the command address and bus_dir_o the direction (1 = write) while bus_astb_o is high. The strobe stays high for exactly DECODE cycles (default 2), and bus_req_o rises in the same cycle the strobe falls.
- R3: A write whose address has upper bits [W-1:2] equal to those of BASE (default 0x40, four registers) stores the data in register addr[1:0]. rsp_err_o reads 0.
- R4: A read of a matching address returns the register contents on rsp_rdata_o with rsp_err_o at 0. The master captures the lines in the cycle it drops request.
- R5: Request falls only after the master has seen acknowledge high, or on timeout. Acknowledge rises only while the slave sees request high, and falls only after the slave sees request low.
- R6: cmd_ready_o is low from the cycle after acceptance until the response. A new address phase never starts while the master's synchronized acknowledge is high.
- R7: An address outside the window never raises acknowledge. Request then stays high for exactly TIMEOUT cycles (default 16), rsp_err_o is 1, and the slave registers are unchanged.
- R8: The master and the slave never drive the shared lines in the same cycle.
- R9: rsp_valid_o is a single-cycle pulse, once per accepted command.
- R10: With two-stage synchronizers, acknowledge rises exactly 3 cycles after request rises, and request falls exactly 3 cycles after acknowledge rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_addr_i | input | W | Target address |
| cmd_wdata_i | input | W | Write data |
| cmd_ready_o | output | 1 | Master idle and able to accept |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | W | Read data captured from the bus |
| rsp_err_o | output | 1 | Transaction timed out with no acknowledge |
| bus_lines_o | output | W | Shared address/data lines |
| bus_astb_o | output | 1 | Address strobe (decode phase) |
| bus_dir_o | output | 1 | Direction line |
| bus_req_o | output | 1 | Master request |
| bus_ack_o | output | 1 | Slave acknowledge |

## Verification
The bench writes every one of the 256 addresses, then reads every address, then rewrites and rereads only the window with inverted values. This separates in-window from out-of-window decoding, tells register indices apart by distinct per-address data, and shows that timed-out writes left the registers untouched. Reading the window before any write shows the reset contents. A bus monitor measures the strobe width, the request-to-acknowledge and acknowledge-to-release latencies, and the request width on misses in every transaction. This separates synchronizer depth, decode delay and timeout count from one another.

// File: rtl/abus_pkg.sv
package abus_pkg;
  typedef enum logic [1:0] {M_IDLE, M_ADDR, M_REQ, M_DONE} m_state_e;
endpackage

// File: rtl/abus_sync.sv
module abus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-2:0], d_i};
  end
  assign q_o = q[STAGES-1];
endmodule

// File: rtl/abus_master.sv
module abus_master
  import abus_pkg::*;
#(
  parameter int W       = 8,
  parameter int DECODE  = 2,
  parameter int TIMEOUT = 16,
  parameter int SYNC    = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cmd_valid_i,
  input  logic         cmd_write_i,
  input  logic [W-1:0] cmd_addr_i,
  input  logic [W-1:0] cmd_wdata_i,
  output logic         cmd_ready_o,
  output logic         rsp_valid_o,
  output logic [W-1:0] rsp_rdata_o,
  output logic         rsp_err_o,
  input  logic [W-1:0] lines_i,
  output logic [W-1:0] lines_o,
  output logic         lines_oe_o,
  output logic         astb_o,
  output logic         dir_o,
  output logic         req_o,
  input  logic         ack_i
);
  localparam int CW = $clog2(DECODE + TIMEOUT + 1);

  m_state_e       state_q;
  logic [CW-1:0]  cnt_q;
  logic [W-1:0]   addr_q, wdata_q, rdata_q;
  logic           wr_q, err_q, rsp_q;
  logic           ack_s;

  abus_sync #(.STAGES(SYNC)) u_ack_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ack_i), .q_o(ack_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= M_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      unique case (state_q)
        M_IDLE: if (cmd_valid_i && !ack_s) begin
          addr_q  <= cmd_addr_i;
          wdata_q <= cmd_wdata_i;
          wr_q    <= cmd_write_i;
          err_q   <= 1'b0;
          cnt_q   <= '0;
          state_q <= M_ADDR;
        end
        M_ADDR: if (cnt_q == CW'(DECODE - 1)) begin
          cnt_q   <= '0;
          state_q <= M_REQ;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        M_REQ: if (ack_s) begin
          if (!wr_q) rdata_q <= lines_i;  // capture while dropping request
          state_q <= M_DONE;
        end else if (cnt_q == CW'(TIMEOUT - 1)) begin
          err_q   <= 1'b1;
          state_q <= M_DONE;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        M_DONE: if (!ack_s) begin
          rsp_q   <= 1'b1;
          state_q <= M_IDLE;
        end
        default: state_q <= M_IDLE;
      endcase
    end
  end

  assign cmd_ready_o = (state_q == M_IDLE) && !ack_s;
  assign rsp_valid_o = rsp_q;
  assign rsp_rdata_o = rdata_q;
  assign rsp_err_o   = err_q;
  assign astb_o      = (state_q == M_ADDR);
  assign req_o       = (state_q == M_REQ);
  assign dir_o       = wr_q && (state_q != M_IDLE);
  assign lines_oe_o  = astb_o || (req_o && wr_q);
  assign lines_o     = astb_o ? addr_q : (lines_oe_o ? wdata_q : '0);

  assert_req_after_decode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(astb_o));
  assert_addr_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (astb_o && $past(astb_o)) |-> $stable(lines_o));
  assert_req_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_o) |-> ($past(ack_s) || rsp_err_o));
  assert_start_ack_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(astb_o) |-> !$past(ack_s));
  assert_rsp_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
endmodule

// File: rtl/abus_slave.sv
module abus_slave #(
  parameter int          W     = 8,
  parameter int          NREGS = 4,
  parameter logic [W-1:0] BASE = 8'h40,
  parameter int          SYNC  = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lines_i,
  output logic [W-1:0] lines_o,
  output logic         lines_oe_o,
  input  logic         astb_i,
  input  logic         dir_i,
  input  logic         req_i,
  output logic         ack_o
);
  localparam int IW = $clog2(NREGS);

  logic [W-1:0]  regs_q [NREGS];
  logic [W-1:0]  addr_q;
  logic          wr_q, ack_q, req_s, hit;
  logic [IW-1:0] idx;

  abus_sync #(.STAGES(SYNC)) u_req_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(req_i), .q_o(req_s)
  );

  assign idx = addr_q[IW-1:0];
  assign hit = (addr_q[W-1:IW] == BASE[W-1:IW]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      wr_q   <= 1'b0;
      ack_q  <= 1'b0;
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else begin
      if (astb_i) begin
        addr_q <= lines_i;
        wr_q   <= dir_i;
      end
      if (!ack_q && req_s && hit) begin
        ack_q <= 1'b1;
        if (wr_q) regs_q[idx] <= lines_i;
      end else if (ack_q && !req_s) begin
        ack_q <= 1'b0;
      end
    end
  end

  assign ack_o      = ack_q;
  assign lines_oe_o = ack_q && !wr_q;
  assign lines_o    = lines_oe_o ? regs_q[idx] : '0;

  assert_ack_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(req_s));
  assert_ack_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_o) |-> !$past(req_s));
  assert_ack_needs_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(req_i, 2));
endmodule

// File: rtl/abus_link.sv
module abus_link #(
  parameter int           W       = 8,
  parameter int           DECODE  = 2,
  parameter int           TIMEOUT = 16,
  parameter int           NREGS   = 4,
  parameter logic [W-1:0] BASE    = 8'h40
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cmd_valid_i,
  input  logic         cmd_write_i,
  input  logic [W-1:0] cmd_addr_i,
  input  logic [W-1:0] cmd_wdata_i,
  output logic         cmd_ready_o,
  output logic         rsp_valid_o,
  output logic [W-1:0] rsp_rdata_o,
  output logic         rsp_err_o,
  output logic [W-1:0] bus_lines_o,
  output logic         bus_astb_o,
  output logic         bus_dir_o,
  output logic         bus_req_o,
  output logic         bus_ack_o
);
  logic [W-1:0] m_lines, s_lines, lines;
  logic         m_oe, s_oe, astb, dir, req, ack;

  abus_master #(.W(W), .DECODE(DECODE), .TIMEOUT(TIMEOUT)) u_master (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid_i), .cmd_write_i(cmd_write_i),
    .cmd_addr_i(cmd_addr_i), .cmd_wdata_i(cmd_wdata_i),
    .cmd_ready_o(cmd_ready_o), .rsp_valid_o(rsp_valid_o),
    .rsp_rdata_o(rsp_rdata_o), .rsp_err_o(rsp_err_o),
    .lines_i(lines), .lines_o(m_lines), .lines_oe_o(m_oe),
    .astb_o(astb), .dir_o(dir), .req_o(req), .ack_i(ack)
  );

  abus_slave #(.W(W), .NREGS(NREGS), .BASE(BASE)) u_slave (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lines_i(lines), .lines_o(s_lines), .lines_oe_o(s_oe),
    .astb_i(astb), .dir_i(dir), .req_i(req), .ack_o(ack)
  );

  // shared lines: whichever side is enabled drives, idle level zero
  assign lines = m_oe ? m_lines : (s_oe ? s_lines : '0);

  assign bus_lines_o = lines;
  assign bus_astb_o  = astb;
  assign bus_dir_o   = dir;
  assign bus_req_o   = req;
  assign bus_ack_o   = ack;

  assert_single_driver_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(m_oe && s_oe));
endmodule

// File: tb/abus_link_test.sv
module abus_link_test;
  localparam int DECODE  = 2;
  localparam int TIMEOUT = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [7:0] cmd_addr = '0, cmd_wdata = '0;
  logic       cmd_ready, rsp_valid, rsp_err;
  logic [7:0] rsp_rdata, bus_lines;
  logic       bus_astb, bus_dir, bus_req, bus_ack;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  abus_link uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_write_i(cmd_write),
    .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata),
    .cmd_ready_o(cmd_ready), .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .bus_lines_o(bus_lines), .bus_astb_o(bus_astb), .bus_dir_o(bus_dir),
    .bus_req_o(bus_req), .bus_ack_o(bus_ack)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [7:0] a);
    return a[7:2] == 6'h10;
  endfunction

  function automatic logic [7:0] pat(input logic [7:0] a);
    return 8'(a * 7 + 3);
  endfunction

  // bus monitor
  logic [7:0] cur_addr;
  logic       cur_wr;
  int cyc = 0, astb_run = 0, t_req = 0, t_ack = 0, ack_rises = 0;
  bit ack_seen = 0;
  logic p_astb = 0, p_req = 0, p_ack = 0, p_rsp = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (bus_astb) begin
        astb_run++;
        chk(bus_lines == cur_addr, "R2 addr on lines", bus_lines, cur_addr);
        chk(bus_dir == cur_wr, "R2 direction", bus_dir, cur_wr);
      end
      if (p_astb && !bus_astb) begin
        chk(astb_run == DECODE, "R2 strobe width", astb_run, DECODE);
        chk(bus_req, "R2 req at strobe end", bus_req, 1);
        astb_run = 0;
      end
      if (!p_req && bus_req) begin t_req = cyc; ack_seen = 0; end
      if (!p_ack && bus_ack) begin
        chk(cyc - t_req == 3, "R10 req-to-ack", cyc - t_req, 3);
        t_ack = cyc; ack_seen = 1; ack_rises++;
      end
      if (p_req && !bus_req) begin
        if (ack_seen) chk(cyc - t_ack == 3, "R10 ack-to-release", cyc - t_ack, 3);
        else chk(cyc - t_req == TIMEOUT, "R7 timeout width", cyc - t_req, TIMEOUT);
      end
      if (p_ack && !bus_ack) chk(!bus_req, "R5 ack falls after req", bus_req, 0);
      if (rsp_valid && p_rsp) chk(0, "R9 rsp pulse width", 2, 1);
      p_astb = bus_astb; p_req = bus_req; p_ack = bus_ack; p_rsp = rsp_valid;
    end
  end

  task automatic txn(input logic wr, input logic [7:0] a, input logic [7:0] d,
                     output logic [7:0] rd, output logic er);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cur_addr = a; cur_wr = wr; ack_rises = 0;
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R6 busy after accept", cmd_ready, 0);
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata; er = rsp_err;
    chk(ack_rises == (in_win(a) ? 1 : 0), "R7 ack only on match", ack_rises, in_win(a));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic er;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cmd_ready, "R1 ready", cmd_ready, 1);
    chk(!bus_req && !bus_ack && !bus_astb, "R1 handshake idle",
        {bus_req, bus_ack, bus_astb}, 0);
    for (int i = 0; i < 4; i++) begin
      txn(1'b0, 8'(8'h40 + i), 8'h00, rd, er);
      chk(rd == 8'h00 && !er, "R1 reg zero", rd, 0);
    end
    // R3/R7 write every address
    for (int a = 0; a < 256; a++) begin
      txn(1'b1, 8'(a), pat(8'(a)), rd, er);
      chk(er == !in_win(8'(a)), "R3 R7 write err", er, !in_win(8'(a)));
    end
    // R4/R7 read every address; misses must not have altered registers
    for (int a = 0; a < 256; a++) begin
      txn(1'b0, 8'(a), 8'h00, rd, er);
      if (in_win(8'(a))) begin
        chk(!er, "R4 read err", er, 0);
        chk(rd == pat(8'(a)), "R4 read data", rd, pat(8'(a)));
      end else begin
        chk(er, "R7 miss err", er, 1);
      end
    end
    // second pattern on the window only
    for (int i = 0; i < 4; i++) txn(1'b1, 8'(8'h40 + i), ~pat(8'(8'h40 + i)), rd, er);
    for (int i = 3; i >= 0; i--) begin
      txn(1'b0, 8'(8'h40 + i), 8'h00, rd, er);
      chk(rd == ~pat(8'(8'h40 + i)) && !er, "R3 R4 rewrite", rd, ~pat(8'(8'h40 + i)));
    end
    repeat (4) @(negedge clk);
    chk(!bus_req && !bus_ack && cmd_ready, "R5 R6 idle at end",
        {bus_req, bus_ack, cmd_ready}, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule